// File: doc/BRIEF.md
# Float-to-Integer Rounding Converter

This block turns an IEEE-754 single-precision value into a 32-bit two's-complement integer. A 2-bit mode input picks one of four ways to dispose of the fraction. All four modes share one datapath: the significand is aligned to the binary point, a guard bit and a sticky bit are collected from the bits shifted out, and a mode-dependent increment is added before the sign is applied.

A conversion is requested by holding `en_i` high for one cycle with the operand and mode. One clock edge later `vld_o` pulses. `ok_o` is high when the converted value fits the integer range, and `res_o` then carries it. When the input is NaN, an infinity, or a value outside the signed 32-bit range, `ok_o` stays low and `res_o` keeps its previous contents. When there is no request, `ok_o` is low.

Top module: `f2i_round`

## Requirements
- R1: Mode 2'b00 (nearest) gives the closest integer. A value exactly halfway between two integers gives the even one (2.5 gives 2, 3.5 gives 4, -2.5 gives -2).
- R2: Mode 2'b01 (truncate) discards the fraction and rounds toward zero (-2.5 gives -2).
- R3: Mode 2'b10 (ceiling) gives the smallest integer not below the input (2.5 gives 3, -2.5 gives -2).
- R4: Mode 2'b11 (floor) gives the largest integer not above the input (2.5 gives 2, -2.5 gives -3).
- R5: A rounded value from -2147483648 to 2147483647 sets `ok_o`=1. Any value beyond that range, such as 2^31, sets `ok_o`=0 and leaves `res_o` unchanged.
- R6: An exponent field (bits 30:23) of all ones, which marks NaN or an infinity of either sign, sets `ok_o`=0 and leaves `res_o` unchanged, whatever the mode.
- R7: A cycle with `en_i`=0 gives `vld_o`=0 and `ok_o`=0 on the next cycle, and `res_o` is unchanged.
- R8: A request with `en_i`=1 produces `vld_o`=1 exactly one clock edge later, together with its `ok_o` and `res_o`.
- R9: Zero and denormals (exponent field 0) convert to 0, with two exceptions: ceiling of a positive nonzero denormal gives 1, and floor of a negative nonzero denormal gives -1.
- R10: While `rst_n` is low, `res_o` is 0 and `ok_o` and `vld_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Conversion request |
| fval_i | input | 32 | Single-precision operand |
| mode_i | input | 2 | Rounding mode: 00 nearest-even, 01 truncate, 10 ceiling, 11 floor |
| res_o | output | 32 | Signed integer result, held when a conversion fails |
| ok_o | output | 1 | Result valid and in range |
| vld_o | output | 1 | Pulses one cycle after a request |

## Verification
Exact ties such as ±0.5, ±1.5, ±2.5 and ±3.5 are run in every mode. They separate the even-tie rule from round-half-away and show which way each directed mode breaks a tie for each sign. Values at the range edges (2^31, -2^31, 2147483520 and the next float above it) show whether the overflow test is one-sided and whether the most negative integer is accepted. NaN, both infinities, zero and the smallest denormals of both signs check the special paths. Random operands with exponents clustered around the integer range check alignment and sticky collection for every shift distance, with idle cycles mixed in to show that the output holds.

// File: rtl/f2i_round.sv
module f2i_round (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en_i,
  input  logic [31:0] fval_i,
  input  logic [1:0]  mode_i,
  output logic [31:0] res_o,
  output logic        ok_o,
  output logic        vld_o
);
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int BIAS   = 127;
  localparam int SH_MAX = FRAC_W + 2;

  logic              sgn;
  logic [EXP_W-1:0]  ex;
  logic [FRAC_W-1:0] fr;
  logic [FRAC_W:0]   mant;
  logic signed [9:0] eu;
  logic signed [9:0] lsd;
  logic signed [9:0] rsd;
  logic [4:0]        rsc;
  logic [25:0]       mw;
  logic [25:0]       q;
  logic              gbit;
  logic              sticky;
  logic              inc;
  logic              is_big;
  logic              special;
  logic              too_big;
  logic              ovf;
  logic [31:0]       mag_big;
  logic [31:0]       mag;
  logic [31:0]       res_n;

  assign sgn  = fval_i[31];
  assign ex   = fval_i[30:23];
  assign fr   = fval_i[22:0];
  assign mant = {(ex != '0), fr};
  assign eu   = (ex == '0) ? (10'sd1 - 10'(BIAS)) : ($signed({2'b00, ex}) - 10'(BIAS));

  assign special = (ex == '1);
  assign too_big = (eu > 10'sd31) || ((eu == 10'sd31) && !(sgn && (fr == '0)));
  assign ovf     = special || too_big;

  assign is_big  = (eu >= 10'(FRAC_W));
  assign lsd     = eu - 10'(FRAC_W);
  assign mag_big = {8'b0, mant} << lsd;

  assign rsd = 10'(FRAC_W) - eu;
  assign rsc = (rsd > 10'(SH_MAX)) ? 5'(SH_MAX) : rsd[4:0];
  assign mw  = {2'b00, mant};
  assign q   = mw >> rsc;

  always_comb begin
    gbit   = 1'b0;
    sticky = 1'b0;
    if (rsc != 5'd0) begin
      gbit   = mw[rsc - 5'd1];
      sticky = |(mw & ((26'd1 << (rsc - 5'd1)) - 26'd1));
    end
  end

  always_comb begin
    case (mode_i)
      2'b00:   inc = gbit & (sticky | q[0]);
      2'b01:   inc = 1'b0;
      2'b10:   inc = !sgn & (gbit | sticky);
      default: inc = sgn & (gbit | sticky);
    endcase
  end

  assign mag   = is_big ? mag_big : ({6'b0, q} + {31'b0, inc});
  assign res_n = sgn ? (~mag + 32'd1) : mag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_o <= '0;
      ok_o  <= 1'b0;
      vld_o <= 1'b0;
    end else begin
      vld_o <= en_i;
      ok_o  <= en_i & !ovf;
      if (en_i && !ovf) res_o <= res_n;
    end
  end
endmodule

module f2i_round_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        en_i,
  input logic [31:0] fval_i,
  input logic [1:0]  mode_i,
  input logic [31:0] res_o,
  input logic        ok_o,
  input logic        vld_o
);
  AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |=> vld_o); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (!vld_o && !ok_o)); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> $stable(res_o)); // R7
  AST_SPECIAL_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && fval_i[30:23] == 8'hFF) |=> (!ok_o && $stable(res_o))); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && fval_i[30:23] > 8'd158) |=> !ok_o); // R5
  AST_TRUNC_SMALL: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && mode_i == 2'b01 && fval_i[30:23] < 8'd127) |=> (ok_o && res_o == 32'd0)); // R2
  AST_DENORM_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && mode_i == 2'b10 && fval_i[31:23] == 9'd0 && fval_i[22:0] != 23'd0) |=> (res_o == 32'd1)); // R9
endmodule

bind f2i_round f2i_round_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en_i(en_i), .fval_i(fval_i), .mode_i(mode_i),
  .res_o(res_o), .ok_o(ok_o), .vld_o(vld_o)
);

// File: tb/tb_f2i_round.sv
module tb_f2i_round;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en_i = 1'b0;
  logic [31:0] fval_i = '0;
  logic [1:0]  mode_i = '0;
  logic [31:0] res_o;
  logic        ok_o;
  logic        vld_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  logic [31:0] m_res = '0;
  logic        m_ok = 1'b0;
  logic        m_vld = 1'b0;
  string       m_tag = "R10";

  always #2 clk = ~clk;

  f2i_round dut (.clk(clk), .rst_n(rst_n), .en_i(en_i), .fval_i(fval_i),
                 .mode_i(mode_i), .res_o(res_o), .ok_o(ok_o), .vld_o(vld_o));

  function automatic real to_real(input logic [31:0] f);
    real mg;
    int e;
    e  = (f[30:23] == 8'd0) ? -149 : (int'(f[30:23]) - 150);
    mg = real'({(f[30:23] != 8'd0), f[22:0]}) * (2.0 ** real'(e));
    return f[31] ? -mg : mg;
  endfunction

  function automatic real round_ref(input real r, input logic [1:0] md);
    real fl, d;
    fl = $floor(r);
    case (md)
      2'b00: begin
        d = r - fl;
        if (d > 0.5) return fl + 1.0;
        if (d < 0.5) return fl;
        if ($floor(fl / 2.0) * 2.0 != fl) return fl + 1.0;
        return fl;
      end
      2'b01:   return (r < 0.0) ? -$floor(-r) : fl;
      2'b10:   return $ceil(r);
      default: return fl;
    endcase
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      m_res = '0; m_ok = 1'b0; m_vld = 1'b0; m_tag = "R10";
    end else begin
      m_vld = en_i;
      m_ok  = 1'b0;
      if (!en_i) m_tag = "R7";
      else if (fval_i[30:23] == 8'hFF) m_tag = "R6";
      else begin
        real rr;
        rr = round_ref(to_real(fval_i), mode_i);
        if (rr < -2147483648.0 || rr > 2147483647.0) m_tag = "R5";
        else begin
          m_ok  = 1'b1;
          m_res = 32'(longint'(rr));
          if (fval_i[30:23] == 8'd0) m_tag = "R9";
          else if (fval_i[30:23] >= 8'd157) m_tag = "R5";
          else case (mode_i)
            2'b00: m_tag = "R1";
            2'b01: m_tag = "R2";
            2'b10: m_tag = "R3";
            default: m_tag = "R4";
          endcase
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      n_chk++;
      if (vld_o !== m_vld) begin
        n_bad++;
        $display("FAIL %s vld: got %0b exp %0b", (m_vld ? "R8" : m_tag), vld_o, m_vld);
      end
      n_chk++;
      if (ok_o !== m_ok || res_o !== m_res) begin
        n_bad++;
        $display("FAIL %s ok/res: got %0b/%h exp %0b/%h", m_tag, ok_o, res_o, m_ok, m_res);
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      n_bad++; n_chk++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  task automatic req(input logic [31:0] f, input logic [1:0] md);
    @(negedge clk);
    en_i = 1'b1; fval_i = f; mode_i = md;
  endtask

  task automatic idle();
    @(negedge clk);
    en_i = 1'b0; fval_i = $urandom; mode_i = 2'($urandom);
  endtask

  localparam int NDIR = 24;
  logic [31:0] dir [NDIR] = '{
    32'h40200000, 32'h40600000, 32'hC0200000, 32'hC0600000,
    32'h3F000000, 32'hBF000000, 32'h3FC00000, 32'hBFC00000,
    32'h4F000000, 32'hCF000000, 32'h4EFFFFFF, 32'hCF000001,
    32'h7FC00000, 32'h7F800000, 32'hFF800000, 32'h00000000,
    32'h80000000, 32'h00000001, 32'h80000001, 32'h007FFFFF,
    32'h3F7FFFFF, 32'hBF800000, 32'h4B7FFFFF, 32'h3EFFFFFF
  };

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NDIR; i++)
      for (int m = 0; m < 4; m++) begin
        req(dir[i], 2'(m));
        if (m == 2) idle();
      end
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] f;
      f = $urandom;
      if (i % 4 != 0) f[30:23] = 8'(110 + ($urandom % 52));
      if ($urandom % 5 == 0) idle();
      req(f, 2'($urandom));
    end
    idle();
    idle();
    @(negedge clk);
    done = 1'b1;
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule